// File: doc/BRIEF.md
# Parameter-Block Floppy Command Engine

This block carries out one diskette command whose description sits in system memory as a seven-byte parameter block. A start pulse supplies the 16-bit address of that block; the engine reads the block one byte at a time through a system-memory port, decodes the operation and the target drive, and validates the request. Once the request passes, it performs the operation. Read and write move whole 128-byte records between a system-memory buffer and a byte-addressed disk-image memory. Format fills a complete track with a single byte.

Each command ends with a one-cycle completion pulse, an error byte, a result type of 00 and a raised interrupt flag that stays up until the next accepted start. Per-drive inputs give readiness, write protection and density. Per-drive position registers hold the most recent seek or recalibrate target. The block models no media timing and generates no CRC.

Top module: `pblk_disk_engine`

## Requirements
- R1: After an accepted start, the first seven system-memory reads fetch the block address plus 0 through 6 in ascending order. Byte 1 carries the operation in bits 2:0 and the drive in bits 5:4. Byte 2 is the record count, byte 3 the track, byte 4 the sector, and bytes 5 (low) and 6 (high) the buffer address.
- R2: If the selected drive's ready input is low, the command finishes with error byte 0x80. This check takes priority over every other check, and the command makes no further memory access.
- R3: Every operation except recalibrate (code 3) finishes with error byte 0x08 when any of the following holds: the sector is 0; the sector is above the last sector; sector plus count is above the last sector plus one; the track is above 76. The last sector is 52 for a drive whose density input is high and 26 otherwise.
- R4: Seek (code 1) loads the drive's position outputs with the track and sector. Recalibrate (code 3) loads track 0 and the given sector.
- R5: Format (2), write (6) and write-deleted (7) on a drive whose write-protect input is high finish with error byte 0x20 and write nothing to the disk image. This check follows the address check.
- R6: Read (code 4) copies count × 128 bytes from the disk image to the buffer. The disk offset of each record is ((track × sectors-per-track) + sector − 1) × 128. Between records the sector advances by 1 and the buffer address by 0x80. A count of 0 moves nothing.
- R7: Write (6) and write-deleted (7) copy buffer bytes into the disk image with the same addressing as R6. The deleted-data mark output is high on each disk write of code 7 and never on code 6.
- R8: Format reads one fill byte at the buffer address. It then writes that byte into sectors-per-track × 128 consecutive disk bytes, starting at the offset computed for the given track and sector.
- R9: A command that passes its checks finishes with error byte 0. Every finished command gives a one-cycle done pulse, result type 00 and the interrupt flag set. No-op (0) and verify (5) make no access beyond the block fetch.
- R10: Busy is high from the cycle after an accepted start through the done pulse. A start arriving while busy is ignored. An accepted start clears the interrupt flag and the error byte.
- R11: On both memory ports, a request stays high with address, direction and write data unchanged until acknowledged, and each transaction moves one byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Start pulse, accepted when idle |
| blk_addr | input | 16 | Parameter block address |
| busy | output | 1 | Command in progress |
| done | output | 1 | One-cycle completion pulse |
| err_byte | output | 8 | Error byte of the last command |
| res_type | output | 2 | Result type, always 00 |
| irq | output | 1 | Interrupt flag |
| drv_ready | input | 4 | Per-drive ready |
| drv_wprot | input | 4 | Per-drive write protect |
| drv_dense | input | 4 | Per-drive density (1 = 52 sectors) |
| sm_req | output | 1 | System memory request |
| sm_we | output | 1 | System memory write |
| sm_addr | output | 16 | System memory byte address |
| sm_wdata | output | 8 | System memory write data |
| sm_rdata | input | 8 | System memory read data |
| sm_ack | input | 1 | System memory acknowledge |
| dm_req | output | 1 | Disk image request |
| dm_we | output | 1 | Disk image write |
| dm_unit | output | 2 | Disk image drive select |
| dm_addr | output | 19 | Disk image byte offset |
| dm_wdata | output | 8 | Disk image write data |
| dm_rdata | input | 8 | Disk image read data |
| dm_ack | input | 1 | Disk image acknowledge |
| dm_delmark | output | 1 | Deleted-data mark with disk writes |
| cur_track | output | 32 | Per-drive track position, 8 bits each |
| cur_sector | output | 32 | Per-drive sector position, 8 bits each |

## Verification
The embedded properties assume the drive ready, write-protect and density inputs stay constant while busy. They also assume each memory acknowledge is a one-cycle pulse that comes only while a request is pending. The stimulus changes drive inputs only between commands, and the memory responders raise acknowledge for exactly one cycle, one cycle after they see a pending request. Parameter blocks use legal field values along with deliberate boundary values for sector, count and track.

// File: rtl/pblk_pkg.sv
package pblk_pkg;
  localparam int NDRV      = 4;
  localparam int TRK_LAST  = 76;
  localparam int SPT_DD    = 52;
  localparam int SPT_SD    = 26;
  localparam int REC_BYTES = 128;
  localparam int REC_AW    = $clog2(REC_BYTES);
  localparam int FMT_CW    = $clog2(SPT_DD * REC_BYTES);
  localparam int DISK_AW   = $clog2((TRK_LAST + 1) * SPT_DD * REC_BYTES);

  typedef enum logic [2:0] {
    OP_NOP = 3'd0, OP_SEEK = 3'd1, OP_FMT = 3'd2, OP_RECAL = 3'd3,
    OP_READ = 3'd4, OP_VERIFY = 3'd5, OP_WRITE = 3'd6, OP_WDEL = 3'd7
  } op_e;

  localparam logic [7:0] ERR_NONE  = 8'h00;
  localparam logic [7:0] ERR_NRDY  = 8'h80;
  localparam logic [7:0] ERR_WPROT = 8'h20;
  localparam logic [7:0] ERR_ADDR  = 8'h08;

  typedef enum logic [3:0] {
    ST_IDLE, ST_FETCH, ST_CHECK, ST_ISSUE, ST_RD_DISK, ST_RD_SYS,
    ST_WR_SYS, ST_WR_DISK, ST_FILL, ST_FMT, ST_DONE
  } st_e;
endpackage

// File: rtl/pblk_byte_port.sv
module pblk_byte_port #(
  parameter int AW = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          go,
  input  logic          go_we,
  input  logic [AW-1:0] go_addr,
  input  logic [7:0]    go_wdata,
  output logic          fin,
  output logic [7:0]    rd_data,
  output logic          req,
  output logic          we,
  output logic [AW-1:0] addr,
  output logic [7:0]    wdata,
  input  logic [7:0]    rdata,
  input  logic          ack
);
  logic          req_q, req_d;
  logic          we_q, we_d;
  logic [AW-1:0] addr_q, addr_d;
  logic [7:0]    wd_q, wd_d;

  always_comb begin
    req_d  = req_q;
    we_d   = we_q;
    addr_d = addr_q;
    wd_d   = wd_q;
    if (req_q && ack) req_d = 1'b0;
    if (go) begin
      req_d  = 1'b1;
      we_d   = go_we;
      addr_d = go_addr;
      wd_d   = go_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q  <= 1'b0;
      we_q   <= 1'b0;
      addr_q <= '0;
      wd_q   <= '0;
    end else begin
      req_q  <= req_d;
      we_q   <= we_d;
      addr_q <= addr_d;
      wd_q   <= wd_d;
    end
  end

  assign fin     = req_q && ack;
  assign rd_data = rdata;
  assign req     = req_q;
  assign we      = we_q;
  assign addr    = addr_q;
  assign wdata   = wd_q;

  // R11
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> req);
  // R11
  req_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req && !ack |=> $stable(addr) && $stable(we) && $stable(wdata));
endmodule

// File: rtl/pblk_addr_check.sv
module pblk_addr_check
  import pblk_pkg::*;
(
  input  op_e        op,
  input  logic       dense,
  input  logic [7:0] sector,
  input  logic [7:0] track,
  input  logic [7:0] count,
  output logic       bad
);
  logic [8:0] last_sec;
  logic [8:0] span_end;

  always_comb begin
    last_sec = dense ? 9'(SPT_DD) : 9'(SPT_SD);
    span_end = {1'b0, sector} + {1'b0, count};
    bad = (op != OP_RECAL) &&
          ((sector == 8'd0) ||
           ({1'b0, sector} > last_sec) ||
           (span_end > last_sec + 9'd1) ||
           (track > 8'(TRK_LAST)));
  end
endmodule

// File: rtl/pblk_offset.sv
module pblk_offset
  import pblk_pkg::*;
#(
  parameter int DAW = DISK_AW
) (
  input  logic [7:0]        track,
  input  logic [7:0]        sector,
  input  logic              dense,
  input  logic [FMT_CW-1:0] bcnt,
  output logic [DAW-1:0]    addr
);
  logic [DAW-1:0] spt;
  logic [DAW-1:0] rec_idx;

  always_comb begin
    spt     = dense ? DAW'(SPT_DD) : DAW'(SPT_SD);
    rec_idx = DAW'(track) * spt + DAW'(sector) - DAW'(1);
    addr    = (rec_idx << REC_AW) + DAW'(bcnt);
  end
endmodule

// File: rtl/pblk_disk_engine.sv
module pblk_disk_engine
  import pblk_pkg::*;
#(
  parameter int DAW = DISK_AW
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              start,
  input  logic [15:0]       blk_addr,
  output logic              busy,
  output logic              done,
  output logic [7:0]        err_byte,
  output logic [1:0]        res_type,
  output logic              irq,
  input  logic [NDRV-1:0]   drv_ready,
  input  logic [NDRV-1:0]   drv_wprot,
  input  logic [NDRV-1:0]   drv_dense,
  output logic              sm_req,
  output logic              sm_we,
  output logic [15:0]       sm_addr,
  output logic [7:0]        sm_wdata,
  input  logic [7:0]        sm_rdata,
  input  logic              sm_ack,
  output logic              dm_req,
  output logic              dm_we,
  output logic [1:0]        dm_unit,
  output logic [DAW-1:0]    dm_addr,
  output logic [7:0]        dm_wdata,
  input  logic [7:0]        dm_rdata,
  input  logic              dm_ack,
  output logic              dm_delmark,
  output logic [NDRV*8-1:0] cur_track,
  output logic [NDRV*8-1:0] cur_sector
);
  localparam int UW = $clog2(NDRV);
  localparam logic [FMT_CW-1:0] REC_LAST = FMT_CW'(REC_BYTES - 1);
  localparam logic [FMT_CW-1:0] FMT_LAST_DD = FMT_CW'(SPT_DD * REC_BYTES - 1);
  localparam logic [FMT_CW-1:0] FMT_LAST_SD = FMT_CW'(SPT_SD * REC_BYTES - 1);

  // reset: asserted asynchronously, released on the clock
  logic rst_m, rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_m <= 1'b0;
      rst_s <= 1'b0;
    end else begin
      rst_m <= 1'b1;
      rst_s <= rst_m;
    end
  end

  st_e              st_q, st_d;
  logic [2:0]       idx_q, idx_d;
  logic [15:0]      blk_q, blk_d;
  op_e              op_q, op_d;
  logic [UW-1:0]    unit_q, unit_d;
  logic [7:0]       cnt_q, cnt_d;
  logic [7:0]       trk_q, trk_d;
  logic [7:0]       sec_q, sec_d;
  logic [15:0]      buf_q, buf_d;
  logic [7:0]       rec_q, rec_d;
  logic [FMT_CW-1:0] bcnt_q, bcnt_d;
  logic [7:0]       fill_q, fill_d;
  logic [7:0]       err_q, err_d;
  logic             irq_q, irq_d;

  logic             pos_we;
  logic [7:0]       pos_trk_d, pos_sec_d;

  logic             sp_go, sp_we, sp_fin;
  logic [15:0]      sp_addr_go;
  logic [7:0]       sp_wd_go, sp_rd;
  logic             dp_go, dp_we, dp_fin;
  logic [DAW-1:0]   dp_addr_go;
  logic [7:0]       dp_wd_go, dp_rd;

  logic             sel_dense, sel_ready, sel_wprot, addr_bad;
  logic [DAW-1:0]   disk_off;
  logic [FMT_CW-1:0] fmt_last;

  assign sel_dense = drv_dense[unit_q];
  assign sel_ready = drv_ready[unit_q];
  assign sel_wprot = drv_wprot[unit_q];
  assign fmt_last  = sel_dense ? FMT_LAST_DD : FMT_LAST_SD;

  pblk_addr_check u_chk (
    .op(op_q), .dense(sel_dense), .sector(sec_q), .track(trk_q),
    .count(cnt_q), .bad(addr_bad)
  );

  pblk_offset #(.DAW(DAW)) u_off (
    .track(trk_q), .sector(sec_q), .dense(sel_dense), .bcnt(bcnt_q),
    .addr(disk_off)
  );

  pblk_byte_port #(.AW(16)) u_sys (
    .clk(clk), .rst_n(rst_s), .go(sp_go), .go_we(sp_we), .go_addr(sp_addr_go),
    .go_wdata(sp_wd_go), .fin(sp_fin), .rd_data(sp_rd),
    .req(sm_req), .we(sm_we), .addr(sm_addr), .wdata(sm_wdata),
    .rdata(sm_rdata), .ack(sm_ack)
  );

  pblk_byte_port #(.AW(DAW)) u_dsk (
    .clk(clk), .rst_n(rst_s), .go(dp_go), .go_we(dp_we), .go_addr(dp_addr_go),
    .go_wdata(dp_wd_go), .fin(dp_fin), .rd_data(dp_rd),
    .req(dm_req), .we(dm_we), .addr(dm_addr), .wdata(dm_wdata),
    .rdata(dm_rdata), .ack(dm_ack)
  );

  always_comb begin
    st_d = st_q; idx_d = idx_q; blk_d = blk_q; op_d = op_q; unit_d = unit_q;
    cnt_d = cnt_q; trk_d = trk_q; sec_d = sec_q; buf_d = buf_q; rec_d = rec_q;
    bcnt_d = bcnt_q; fill_d = fill_q; err_d = err_q; irq_d = irq_q;
    pos_we = 1'b0; pos_trk_d = trk_q; pos_sec_d = sec_q;
    sp_go = 1'b0; sp_we = 1'b0; sp_addr_go = buf_q + 16'(bcnt_q); sp_wd_go = dp_rd;
    dp_go = 1'b0; dp_we = 1'b0; dp_addr_go = disk_off; dp_wd_go = sp_rd;

    case (st_q)
      ST_IDLE: begin
        if (start) begin
          blk_d = blk_addr;
          idx_d = 3'd0;
          irq_d = 1'b0;
          err_d = ERR_NONE;
          sp_go = 1'b1;
          sp_addr_go = blk_addr;
          st_d = ST_FETCH;
        end
      end
      ST_FETCH: begin
        if (sp_fin) begin
          case (idx_q)
            3'd1: begin op_d = op_e'(sp_rd[2:0]); unit_d = UW'(sp_rd[5:4]); end
            3'd2: cnt_d = sp_rd;
            3'd3: trk_d = sp_rd;
            3'd4: sec_d = sp_rd;
            3'd5: buf_d[7:0] = sp_rd;
            3'd6: buf_d[15:8] = sp_rd;
            default: ;
          endcase
          if (idx_q == 3'd6) begin
            st_d = ST_CHECK;
          end else begin
            idx_d = idx_q + 3'd1;
            sp_go = 1'b1;
            sp_addr_go = blk_q + 16'(idx_q) + 16'd1;
          end
        end
      end
      ST_CHECK: begin
        rec_d = 8'd0;
        bcnt_d = '0;
        st_d = ST_DONE;
        irq_d = 1'b1;
        err_d = ERR_NONE;
        if (!sel_ready) begin
          err_d = ERR_NRDY;
        end else if (addr_bad) begin
          err_d = ERR_ADDR;
        end else begin
          case (op_q)
            OP_SEEK: begin
              pos_we = 1'b1; pos_trk_d = trk_q; pos_sec_d = sec_q;
            end
            OP_RECAL: begin
              pos_we = 1'b1; pos_trk_d = 8'd0; pos_sec_d = sec_q;
            end
            OP_FMT: begin
              if (sel_wprot) begin
                err_d = ERR_WPROT;
              end else begin
                irq_d = irq_q;
                sp_go = 1'b1;
                sp_addr_go = buf_q;
                st_d = ST_FILL;
              end
            end
            OP_READ, OP_WRITE, OP_WDEL: begin
              if (op_q != OP_READ && sel_wprot) begin
                err_d = ERR_WPROT;
              end else if (cnt_q != 8'd0) begin
                irq_d = irq_q;
                st_d = ST_ISSUE;
              end
            end
            default: ;
          endcase
        end
      end
      ST_ISSUE: begin
        if (op_q == OP_READ) begin
          dp_go = 1'b1;
          st_d = ST_RD_DISK;
        end else if (op_q == OP_FMT) begin
          dp_go = 1'b1; dp_we = 1'b1; dp_wd_go = fill_q;
          st_d = ST_FMT;
        end else begin
          sp_go = 1'b1;
          st_d = ST_WR_SYS;
        end
      end
      ST_RD_DISK: begin
        if (dp_fin) begin
          sp_go = 1'b1; sp_we = 1'b1; sp_wd_go = dp_rd;
          st_d = ST_RD_SYS;
        end
      end
      ST_WR_SYS: begin
        if (sp_fin) begin
          dp_go = 1'b1; dp_we = 1'b1; dp_wd_go = sp_rd;
          st_d = ST_WR_DISK;
        end
      end
      ST_RD_SYS, ST_WR_DISK: begin
        if ((st_q == ST_RD_SYS && sp_fin) || (st_q == ST_WR_DISK && dp_fin)) begin
          st_d = ST_ISSUE;
          if (bcnt_q == REC_LAST) begin
            bcnt_d = '0;
            sec_d = sec_q + 8'd1;
            buf_d = buf_q + 16'(REC_BYTES);
            rec_d = rec_q + 8'd1;
            if (rec_q + 8'd1 == cnt_q) begin
              st_d = ST_DONE;
              irq_d = 1'b1;
            end
          end else begin
            bcnt_d = bcnt_q + 1'b1;
          end
        end
      end
      ST_FILL: begin
        if (sp_fin) begin
          fill_d = sp_rd;
          st_d = ST_ISSUE;
        end
      end
      ST_FMT: begin
        if (dp_fin) begin
          if (bcnt_q == fmt_last) begin
            st_d = ST_DONE;
            irq_d = 1'b1;
          end else begin
            bcnt_d = bcnt_q + 1'b1;
            st_d = ST_ISSUE;
          end
        end
      end
      ST_DONE: st_d = ST_IDLE;
      default: st_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_s) begin
    if (!rst_s) begin
      st_q <= ST_IDLE; idx_q <= '0; blk_q <= '0; op_q <= OP_NOP; unit_q <= '0;
      cnt_q <= '0; trk_q <= '0; sec_q <= '0; buf_q <= '0; rec_q <= '0;
      bcnt_q <= '0; fill_q <= '0; err_q <= '0; irq_q <= 1'b0;
    end else begin
      st_q <= st_d; idx_q <= idx_d; blk_q <= blk_d; op_q <= op_d; unit_q <= unit_d;
      cnt_q <= cnt_d; trk_q <= trk_d; sec_q <= sec_d; buf_q <= buf_d; rec_q <= rec_d;
      bcnt_q <= bcnt_d; fill_q <= fill_d; err_q <= err_d; irq_q <= irq_d;
    end
  end

  for (genvar g = 0; g < NDRV; g++) begin : g_pos
    logic [7:0] trk_pos_q, sec_pos_q;
    always_ff @(posedge clk or negedge rst_s) begin
      if (!rst_s) begin
        trk_pos_q <= '0;
        sec_pos_q <= '0;
      end else if (pos_we && unit_q == UW'(g)) begin
        trk_pos_q <= pos_trk_d;
        sec_pos_q <= pos_sec_d;
      end
    end
    assign cur_track[g*8 +: 8]  = trk_pos_q;
    assign cur_sector[g*8 +: 8] = sec_pos_q;
  end

  assign busy       = (st_q != ST_IDLE);
  assign done       = (st_q == ST_DONE);
  assign err_byte   = err_q;
  assign res_type   = 2'b00;
  assign irq        = irq_q;
  assign dm_unit    = 2'(unit_q);
  assign dm_delmark = dm_req && dm_we && (op_q == OP_WDEL);

  // R10
  busy_done_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> busy);
  // R9
  done_pulse_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |=> !done);
  // R9
  irq_done_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> irq);
  // R10
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_s)
    !busy |-> !sm_req && !dm_req);
  // R2
  nrdy_disk_chk: assert property (@(posedge clk) disable iff (!rst_s)
    dm_req |-> drv_ready[dm_unit]);
  // R5
  wprot_write_chk: assert property (@(posedge clk) disable iff (!rst_s)
    dm_req && dm_we |-> !drv_wprot[dm_unit]);
  // R3
  err_onehot_chk: assert property (@(posedge clk) disable iff (!rst_s)
    done |-> $onehot0(err_byte));
  // R7
  mark_write_chk: assert property (@(posedge clk) disable iff (!rst_s)
    dm_delmark |-> dm_we && dm_req);
endmodule

// File: tb/tb_pblk_disk_engine.sv
module tb_pblk_disk_engine;
  import pblk_pkg::*;
  localparam int DAW = DISK_AW;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n, start, busy, done, irq;
  logic [15:0] blk_addr;
  logic [7:0] err_byte;
  logic [1:0] res_type;
  logic [3:0] drv_ready, drv_wprot, drv_dense;
  logic sm_req, sm_we, sm_ack;
  logic [15:0] sm_addr;
  logic [7:0] sm_wdata, sm_rdata;
  logic dm_req, dm_we, dm_ack, dm_delmark;
  logic [1:0] dm_unit;
  logic [DAW-1:0] dm_addr;
  logic [7:0] dm_wdata, dm_rdata;
  logic [31:0] cur_track, cur_sector;

  pblk_disk_engine dut (
    .clk(clk), .rst_n(rst_n), .start(start), .blk_addr(blk_addr),
    .busy(busy), .done(done), .err_byte(err_byte), .res_type(res_type), .irq(irq),
    .drv_ready(drv_ready), .drv_wprot(drv_wprot), .drv_dense(drv_dense),
    .sm_req(sm_req), .sm_we(sm_we), .sm_addr(sm_addr), .sm_wdata(sm_wdata),
    .sm_rdata(sm_rdata), .sm_ack(sm_ack),
    .dm_req(dm_req), .dm_we(dm_we), .dm_unit(dm_unit), .dm_addr(dm_addr),
    .dm_wdata(dm_wdata), .dm_rdata(dm_rdata), .dm_ack(dm_ack), .dm_delmark(dm_delmark),
    .cur_track(cur_track), .cur_sector(cur_sector)
  );

  int checks = 0;
  int fails = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input longint act, input longint exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // memory models
  logic [7:0] smem [int];
  logic [7:0] dmem [int];

  function automatic logic [7:0] sget(input int a);
    if (smem.exists(a)) return smem[a];
    return 8'((a & 255) ^ ((a >> 8) & 255) ^ 8'h3C);
  endfunction

  function automatic int dkey(input int u, input int a);
    return (u << 20) | a;
  endfunction

  function automatic logic [7:0] dget(input int u, input int a);
    int k;
    k = dkey(u, a);
    if (dmem.exists(k)) return dmem[k];
    return 8'((a & 255) + ((a >> 8) & 255) * 5 + u * 37 + 1);
  endfunction

  int n_srd, n_swr, n_drd, n_dwr, n_dmk, hs_viol;
  int fetch_log[$];
  logic p_sreq, p_sack, p_dreq, p_dack;
  logic [15:0] p_saddr;
  logic [DAW-1:0] p_daddr;

  always @(posedge clk) begin
    if (!rst_n) begin
      sm_ack <= 1'b0; dm_ack <= 1'b0; sm_rdata <= '0; dm_rdata <= '0;
      p_sreq <= 1'b0; p_sack <= 1'b0; p_dreq <= 1'b0; p_dack <= 1'b0;
      p_saddr <= '0; p_daddr <= '0;
    end else begin
      // R11 handshake observation
      if (p_sreq && !p_sack && (!sm_req || sm_addr != p_saddr)) hs_viol++;
      if (p_dreq && !p_dack && (!dm_req || dm_addr != p_daddr)) hs_viol++;
      p_sreq <= sm_req; p_sack <= sm_ack; p_saddr <= sm_addr;
      p_dreq <= dm_req; p_dack <= dm_ack; p_daddr <= dm_addr;
      if (sm_req && !sm_ack) begin
        sm_ack <= 1'b1;
        if (sm_we) begin
          smem[int'(sm_addr)] = sm_wdata;
          n_swr++;
        end else begin
          sm_rdata <= sget(int'(sm_addr));
          n_srd++;
          if (fetch_log.size() < 7) fetch_log.push_back(int'(sm_addr));
        end
      end else begin
        sm_ack <= 1'b0;
      end
      if (dm_req && !dm_ack) begin
        dm_ack <= 1'b1;
        if (dm_we) begin
          dmem[dkey(int'(dm_unit), int'(dm_addr))] = dm_wdata;
          n_dwr++;
          if (dm_delmark) n_dmk++;
        end else begin
          dm_rdata <= dget(int'(dm_unit), int'(dm_addr));
          n_drd++;
        end
      end else begin
        dm_ack <= 1'b0;
      end
    end
  end

  // scoreboard
  typedef struct {
    logic [7:0] err;
    int srd, swr, drd, dwr, dmk;
    string tag;
  } exp_t;
  exp_t sb[$];

  always @(negedge clk) begin
    if (rst_n && done) begin
      if (sb.size() == 0) begin
        chk(1'b0, "R9", "done without command", 1, 0);
      end else begin
        exp_t e;
        e = sb.pop_front();
        chk(err_byte == e.err, e.tag, "error byte", err_byte, e.err);
        chk(irq == 1'b1 && res_type == 2'b00, "R9", "irq/result type",
            {irq, res_type}, 3'b100);
        chk(n_srd == e.srd, e.tag, "system reads", n_srd, e.srd);
        chk(n_swr == e.swr, e.tag, "system writes", n_swr, e.swr);
        chk(n_drd == e.drd, e.tag, "disk reads", n_drd, e.drd);
        chk(n_dwr == e.dwr, e.tag, "disk writes", n_dwr, e.dwr);
        chk(n_dmk == e.dmk, "R7", "deleted mark writes", n_dmk, e.dmk);
      end
    end
  end

  function automatic int spt_of(input int u);
    return drv_dense[u] ? SPT_DD : SPT_SD;
  endfunction

  task automatic run_cmd(input int u, input int op, input int cnt, input int trk,
                         input int sec, input int bufa, input int blk,
                         input string tag, input bit intrude);
    exp_t e;
    int last;
    last = spt_of(u);
    smem[blk]     = 8'h00;
    smem[blk + 1] = 8'((u << 4) | op);
    smem[blk + 2] = 8'(cnt);
    smem[blk + 3] = 8'(trk);
    smem[blk + 4] = 8'(sec);
    smem[blk + 5] = 8'(bufa & 255);
    smem[blk + 6] = 8'(bufa >> 8);
    e.tag = tag; e.srd = 7; e.swr = 0; e.drd = 0; e.dwr = 0; e.dmk = 0;
    if (!drv_ready[u]) e.err = ERR_NRDY;
    else if (op != 3 && (sec == 0 || sec > last || sec + cnt > last + 1 || trk > TRK_LAST))
      e.err = ERR_ADDR;
    else if ((op == 2 || op == 6 || op == 7) && drv_wprot[u]) e.err = ERR_WPROT;
    else e.err = ERR_NONE;
    if (e.err == ERR_NONE) begin
      case (op)
        2: begin e.srd = 8; e.dwr = last * REC_BYTES; end
        4: begin e.drd = cnt * REC_BYTES; e.swr = cnt * REC_BYTES; end
        6, 7: begin
          e.srd = 7 + cnt * REC_BYTES;
          e.dwr = cnt * REC_BYTES;
          e.dmk = (op == 7) ? e.dwr : 0;
        end
        default: ;
      endcase
    end
    sb.push_back(e);
    n_srd = 0; n_swr = 0; n_drd = 0; n_dwr = 0; n_dmk = 0;
    fetch_log.delete();
    @(negedge clk);
    start = 1'b1; blk_addr = 16'(blk);
    @(negedge clk);
    start = 1'b0;
    chk(irq == 1'b0 && busy == 1'b1, "R10", "start clears irq and raises busy",
        {irq, busy}, 2'b01);
    if (intrude) begin
      repeat (30) @(negedge clk);
      start = 1'b1; blk_addr = 16'h0F00;
      @(negedge clk);
      start = 1'b0;
    end
    while (!done) @(negedge clk);
    @(negedge clk);
    chk(busy == 1'b0, "R10", "busy falls after done", busy, 0);
    begin
      bit ok;
      ok = (fetch_log.size() == 7);
      for (int i = 0; i < 7 && ok; i++) if (fetch_log[i] != blk + i) ok = 1'b0;
      chk(ok, "R1", "block fetch order", fetch_log.size(), 7);
    end
  endtask

  task automatic check_read(input int u, input int cnt, input int trk, input int sec,
                            input int bufa);
    int bad = 0;
    for (int r = 0; r < cnt; r++)
      for (int i = 0; i < REC_BYTES; i++)
        if (sget((bufa + r * REC_BYTES + i) & 16'hFFFF) !=
            dget(u, ((trk * spt_of(u)) + sec + r - 1) * REC_BYTES + i)) bad++;
    chk(bad == 0, "R6", "read data placement", bad, 0);
  endtask

  task automatic check_write(input int u, input int cnt, input int trk, input int sec,
                             input int bufa);
    int bad = 0;
    for (int r = 0; r < cnt; r++)
      for (int i = 0; i < REC_BYTES; i++)
        if (dget(u, ((trk * spt_of(u)) + sec + r - 1) * REC_BYTES + i) !=
            sget((bufa + r * REC_BYTES + i) & 16'hFFFF)) bad++;
    chk(bad == 0, "R7", "write data placement", bad, 0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int base;
    int bad;
    rst_n = 1'b0; start = 1'b0; blk_addr = '0;
    drv_ready = 4'b1011; drv_wprot = 4'b0010; drv_dense = 4'b0011;
    hs_viol = 0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk(busy == 0 && done == 0 && irq == 0 && err_byte == 0, "R10", "reset outputs",
        {busy, done, irq, err_byte}, 0);
    chk(sm_req == 0 && dm_req == 0 && cur_track == 0 && cur_sector == 0, "R4",
        "reset ports and positions", {sm_req, dm_req}, 0);

    run_cmd(0, 0, 0, 0, 1, 16'h2000, 16'h0100, "R9", 0);
    run_cmd(3, 5, 1, 76, 26, 16'h2000, 16'h0180, "R3", 0);
    run_cmd(2, 4, 1, 0, 0, 16'h2000, 16'h0100, "R2", 0);
    run_cmd(0, 1, 0, 0, 0, 16'h2000, 16'h0100, "R3", 0);
    run_cmd(0, 5, 1, 0, 53, 16'h2000, 16'h0100, "R3", 0);
    run_cmd(0, 5, 4, 0, 50, 16'h2000, 16'h0100, "R3", 0);
    run_cmd(0, 5, 3, 0, 50, 16'h2000, 16'h0100, "R3", 0);
    run_cmd(3, 5, 1, 0, 27, 16'h2000, 16'h0100, "R3", 0);
    run_cmd(0, 1, 0, 77, 1, 16'h2000, 16'h0100, "R3", 0);

    run_cmd(0, 1, 0, 10, 5, 16'h2000, 16'h0100, "R4", 0);
    chk(cur_track[7:0] == 10 && cur_sector[7:0] == 5, "R4", "seek position",
        {cur_track[7:0], cur_sector[7:0]}, 16'h0A05);
    run_cmd(0, 3, 200, 99, 0, 16'h2000, 16'h0100, "R3", 0);
    chk(cur_track[7:0] == 0 && cur_sector[7:0] == 0, "R4", "recalibrate position",
        {cur_track[7:0], cur_sector[7:0]}, 0);

    run_cmd(1, 6, 1, 1, 1, 16'h2000, 16'h0100, "R5", 0);
    run_cmd(1, 2, 0, 1, 1, 16'h2000, 16'h0100, "R5", 0);
    run_cmd(1, 7, 1, 1, 1, 16'h2000, 16'h0100, "R5", 0);
    run_cmd(1, 6, 1, 1, 0, 16'h2000, 16'h0100, "R3", 0);

    run_cmd(0, 4, 2, 3, 51, 16'h2000, 16'h0100, "R6", 1);
    check_read(0, 2, 3, 51, 16'h2000);
    run_cmd(1, 4, 1, 7, 2, 16'h2400, 16'h0100, "R6", 0);
    check_read(1, 1, 7, 2, 16'h2400);
    run_cmd(0, 4, 0, 3, 1, 16'h2800, 16'h0100, "R6", 0);

    run_cmd(3, 6, 2, 2, 25, 16'h3000, 16'h0100, "R7", 0);
    check_write(3, 2, 2, 25, 16'h3000);
    run_cmd(0, 7, 1, 1, 1, 16'h3200, 16'h0100, "R7", 0);
    check_write(0, 1, 1, 1, 16'h3200);

    smem[16'h4000] = 8'hE5;
    run_cmd(3, 2, 0, 5, 1, 16'h4000, 16'h0100, "R8", 0);
    base = 5 * SPT_SD * REC_BYTES;
    bad = 0;
    for (int i = 0; i < SPT_SD * REC_BYTES; i++) if (dget(3, base + i) != 8'hE5) bad++;
    chk(bad == 0, "R8", "track fill", bad, 0);
    chk(dget(3, base - 1) != 8'hE5 || !dmem.exists(dkey(3, base - 1)), "R8",
        "byte before track untouched", dmem.exists(dkey(3, base - 1)), 0);
    chk(!dmem.exists(dkey(3, base + SPT_SD * REC_BYTES)), "R8",
        "byte after track untouched", dmem.exists(dkey(3, base + SPT_SD * REC_BYTES)), 0);

    repeat (5) @(negedge clk);
    chk(sb.size() == 0, "R9", "all completions seen", sb.size(), 0);
    chk(hs_viol == 0, "R11", "request held until acknowledge", hs_viol, 0);

    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule